// File: doc/BRIEF.md
# CAN Bit Timing Synchronizer

This block divides each nominal bit on a CAN-style bus into four consecutive parts: a one-quantum synchronization segment, a propagation segment, and two phase buffer segments. It moves one quantum forward on every pulse of an externally generated time-quantum tick. The receiver stays aligned to the transmitter by watching for recessive-to-dominant transitions on the receive line. That line is already synchronized to the clock and is looked at only on quantum ticks.

The first falling edge after reset, or after the bus has gone idle, hard-synchronizes the bit timer. That edge's quantum is taken as the synchronization segment. On later edges the timer resynchronizes instead. An edge before the sample point lengthens phase segment 1. An edge after it shortens phase segment 2. In both cases the correction is limited to the configured jump width, and only one correction is made per bit.

The block presents three results for frame logic: a sample strobe with the sampled level, a strobe for the start of each bit, and a flag that shows when a start-of-frame hard synchronization is armed.

Top module: `can_bit_sync`

## Requirements
- R1: The synchronization segment lasts one quantum. Without edges, consecutive `bit_start` pulses are exactly 1 + Tprop + Tph1 + Tph2 quanta apart.
- R2: Tprop = `cfg_prop` + 1 and Tph1 = `cfg_ph1` + 1, so each ranges from 1 to 8 quanta. The jump width is `cfg_sjw` + 1, from 1 to 4 quanta.
- R3: Tph2 is the larger of Tph1 and the processing time. The processing time is `cfg_ipt`, with values above 2 treated as 2.
- R4: `sample_stb` pulses for the last quantum of phase segment 1. At that pulse `rx_bit` takes the `rx_in` level of that quantum and holds it until the next sample. A sample and a bit start never occur in the same cycle.
- R5: Only a 1-to-0 change of `rx_in` between two consecutive ticks counts as an edge. A 0-to-1 change leaves the timing unchanged.
- R6: An edge while armed makes its own quantum the synchronization segment, whatever the current position in the bit and with no jump-width limit. `bit_start` pulses for that quantum.
- R7: `sof_armed` is 1 after reset. It drops with the hard synchronization. It rises again at the sample that completes 11 consecutive recessive samples.
- R8: When not armed, an edge k quanta after the synchronization segment but no later than the sample point lengthens phase segment 1 by min(k, jump width).
- R9: When not armed, an edge in phase segment 2 with r quanta left in the bit (the current quantum included) shortens phase segment 2 by min(r, jump width). If r exceeds the jump width, the bit then ends normally at the shortened length.
- R10: If r is no more than the jump width, the edge's quantum itself becomes the synchronization segment of a new bit, and `bit_start` pulses for it.
- R11: At most one correction (R6, R8, R9 or R10) is made per bit. An edge inside the synchronization segment causes none.
- R12: During and right after reset, `sample_stb` = 0, `bit_start` = 0, `rx_bit` = 1 and `sof_armed` = 1. The first tick after reset is treated as a synchronization segment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tq_tick | input | 1 | One-cycle pulse marking one time quantum |
| rx_in | input | 1 | Synchronized receive level, 1 = recessive |
| cfg_prop | input | PROP_W (3) | Propagation segment length minus one |
| cfg_ph1 | input | PH1_W (3) | Phase segment 1 length minus one |
| cfg_ipt | input | IPT_W (2) | Processing time in quanta, 0 to 2 |
| cfg_sjw | input | SJW_W (2) | Jump width minus one |
| sample_stb | output | 1 | Pulse for the sample-point quantum |
| rx_bit | output | 1 | Most recently sampled bit level |
| bit_start | output | 1 | Pulse for the synchronization-segment quantum |
| sof_armed | output | 1 | Start-of-frame hard synchronization armed |

## Verification
A wrong segment counter or a stale correction register shows up at the ports within one bit time. It appears as a `bit_start` or `sample_stb` pulse one or more ticks away from the expected quantum, and every later bit stays shifted, so the next pulse shows it. A correction flag that is not cleared shows up as an edge in the following bit that fails to move the timing. A wrong idle count appears as `sof_armed` rising at the wrong sample. It can also appear as a later edge hard-synchronizing when it should only resynchronize. These two cases are told apart by placing that edge where the two rules give different sample points.

// File: rtl/can_bt_pkg.sv
`timescale 1ns/1ps
package can_bt_pkg;

    // Width of every segment length and position counter.
    localparam int LEN_W = 5;

    typedef logic [LEN_W-1:0] len_t;

    localparam len_t LEN_ZERO = len_t'(0);
    localparam len_t LEN_ONE  = len_t'(1);

    typedef enum logic [1:0] {
        SEG_SYNC = 2'd0,
        SEG_PROP = 2'd1,
        SEG_PH1  = 2'd2,
        SEG_PH2  = 2'd3
    } seg_e;

    // Decoded segment lengths in quanta.
    typedef struct packed {
        len_t prop;
        len_t ph1;
        len_t ph2;
        len_t sjw;
    } bt_len_t;

    // Per-quantum decisions produced by the timer.
    typedef struct packed {
        logic hard;
        logic sample;
        logic boundary;
    } bt_evt_t;

    function automatic len_t len_min(input len_t a, input len_t b);
        return (a < b) ? a : b;
    endfunction

    function automatic len_t len_max(input len_t a, input len_t b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/can_bt_cfg.sv
`timescale 1ns/1ps
module can_bt_cfg
    import can_bt_pkg::*;
#(
    parameter int PROP_W  = 3,
    parameter int PH1_W   = 3,
    parameter int IPT_W   = 2,
    parameter int SJW_W   = 2,
    parameter int IPT_MAX = 2
) (
    input  logic [PROP_W-1:0] cfg_prop,
    input  logic [PH1_W-1:0]  cfg_ph1,
    input  logic [IPT_W-1:0]  cfg_ipt,
    input  logic [SJW_W-1:0]  cfg_sjw,
    output bt_len_t           len
);
    localparam len_t IPT_CAP = len_t'(IPT_MAX);

    len_t ipt_raw;
    len_t ipt_lim;

    always_comb begin
        ipt_raw  = len_t'(cfg_ipt);
        ipt_lim  = (ipt_raw > IPT_CAP) ? IPT_CAP : ipt_raw;
        len.prop = len_t'(cfg_prop) + LEN_ONE;
        len.ph1  = len_t'(cfg_ph1) + LEN_ONE;
        len.ph2  = len_max(len_t'(cfg_ph1) + LEN_ONE, ipt_lim);
        len.sjw  = len_t'(cfg_sjw) + LEN_ONE;
    end
endmodule

// File: rtl/can_bt_edge.sv
`timescale 1ns/1ps
module can_bt_edge (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic rx,
    output logic fall
);
    logic rx_last_q;

    // Level seen at the previous quantum tick, recessive out of reset.
    always_ff @(posedge clk) begin
        if (rst)       rx_last_q <= 1'b1;
        else if (tick) rx_last_q <= rx;
    end

    assign fall = tick & rx_last_q & ~rx;
endmodule

// File: rtl/can_bt_timer.sv
`timescale 1ns/1ps
module can_bt_timer
    import can_bt_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    tick,
    input  logic    fall,
    input  logic    rx,
    input  logic    armed,
    input  bt_len_t len,
    output bt_evt_t evt,
    output logic    sample_stb,
    output logic    rx_bit,
    output logic    bit_start
);
    seg_e seg_q, seg_d;
    len_t cnt_q, cnt_d;
    len_t ext_q, ext_d;
    len_t shr_q, shr_d;
    logic done_q, done_d;

    logic resync;
    len_t pos_err;
    len_t neg_err;
    len_t ext_w;
    len_t shr_try;

    always_comb begin
        seg_d  = seg_q;
        cnt_d  = cnt_q;
        ext_d  = ext_q;
        shr_d  = shr_q;
        done_d = done_q;
        evt    = '0;

        resync  = fall & ~armed & ~done_q & (seg_q != SEG_SYNC);
        pos_err = (seg_q == SEG_PROP) ? cnt_q + LEN_ONE
                                      : len.prop + cnt_q + LEN_ONE;
        neg_err = len.ph2 - cnt_q;
        ext_w   = resync ? len_min(pos_err, len.sjw) : ext_q;
        shr_try = len_min(neg_err, len.sjw);

        if (tick) begin
            if (fall && armed) begin
                // Hard synchronization: this quantum is the sync segment.
                evt.hard     = 1'b1;
                evt.boundary = 1'b1;
                seg_d  = SEG_PROP;
                cnt_d  = LEN_ZERO;
                ext_d  = LEN_ZERO;
                shr_d  = LEN_ZERO;
                done_d = 1'b1;
            end else begin
                unique case (seg_q)
                    SEG_SYNC: begin
                        evt.boundary = 1'b1;
                        seg_d  = SEG_PROP;
                        cnt_d  = LEN_ZERO;
                        ext_d  = LEN_ZERO;
                        shr_d  = LEN_ZERO;
                        done_d = 1'b0;
                    end
                    SEG_PROP: begin
                        ext_d = ext_w;
                        if (resync) done_d = 1'b1;
                        if (cnt_q + LEN_ONE >= len.prop) begin
                            seg_d = SEG_PH1;
                            cnt_d = LEN_ZERO;
                        end else begin
                            cnt_d = cnt_q + LEN_ONE;
                        end
                    end
                    SEG_PH1: begin
                        ext_d = ext_w;
                        if (resync) done_d = 1'b1;
                        if (cnt_q + LEN_ONE >= len.ph1 + ext_w) begin
                            evt.sample = 1'b1;
                            seg_d = SEG_PH2;
                            cnt_d = LEN_ZERO;
                        end else begin
                            cnt_d = cnt_q + LEN_ONE;
                        end
                    end
                    SEG_PH2: begin
                        if (resync && (shr_try == neg_err)) begin
                            // Shortened segment already over: new bit now.
                            evt.boundary = 1'b1;
                            seg_d  = SEG_PROP;
                            cnt_d  = LEN_ZERO;
                            ext_d  = LEN_ZERO;
                            shr_d  = LEN_ZERO;
                            done_d = 1'b1;
                        end else begin
                            if (resync) begin
                                shr_d  = shr_try;
                                done_d = 1'b1;
                            end
                            if (cnt_q + LEN_ONE + shr_d >= len.ph2) begin
                                seg_d = SEG_SYNC;
                                cnt_d = LEN_ZERO;
                            end else begin
                                cnt_d = cnt_q + LEN_ONE;
                            end
                        end
                    end
                    default: begin
                        seg_d = SEG_SYNC;
                        cnt_d = LEN_ZERO;
                    end
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            seg_q      <= SEG_SYNC;
            cnt_q      <= LEN_ZERO;
            ext_q      <= LEN_ZERO;
            shr_q      <= LEN_ZERO;
            done_q     <= 1'b0;
            sample_stb <= 1'b0;
            bit_start  <= 1'b0;
            rx_bit     <= 1'b1;
        end else begin
            seg_q      <= seg_d;
            cnt_q      <= cnt_d;
            ext_q      <= ext_d;
            shr_q      <= shr_d;
            done_q     <= done_d;
            sample_stb <= evt.sample;
            bit_start  <= evt.boundary;
            if (evt.sample) rx_bit <= rx;
        end
    end
endmodule

// File: rtl/can_bt_idle.sv
`timescale 1ns/1ps
module can_bt_idle #(
    parameter int IDLE_BITS = 11
) (
    input  logic clk,
    input  logic rst,
    input  logic sample_now,
    input  logic rx,
    input  logic hard_now,
    output logic armed
);
    localparam int CW = $clog2(IDLE_BITS + 1);
    localparam logic [CW-1:0] RUN_FULL = CW'(IDLE_BITS);
    localparam logic [CW-1:0] RUN_LAST = CW'(IDLE_BITS - 1);
    localparam logic [CW-1:0] RUN_ONE  = CW'(1);

    logic [CW-1:0] run_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q <= '0;
            armed <= 1'b1;
        end else if (hard_now) begin
            run_q <= '0;
            armed <= 1'b0;
        end else if (sample_now) begin
            if (rx) begin
                if (run_q != RUN_FULL) run_q <= run_q + RUN_ONE;
                if (run_q == RUN_LAST) armed <= 1'b1;
            end else begin
                run_q <= '0;
            end
        end
    end
endmodule

// File: rtl/can_bit_sync.sv
`timescale 1ns/1ps
module can_bit_sync
    import can_bt_pkg::*;
#(
    parameter int PROP_W    = 3,
    parameter int PH1_W     = 3,
    parameter int IPT_W     = 2,
    parameter int SJW_W     = 2,
    parameter int IDLE_BITS = 11
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tq_tick,
    input  logic              rx_in,
    input  logic [PROP_W-1:0] cfg_prop,
    input  logic [PH1_W-1:0]  cfg_ph1,
    input  logic [IPT_W-1:0]  cfg_ipt,
    input  logic [SJW_W-1:0]  cfg_sjw,
    output logic              sample_stb,
    output logic              rx_bit,
    output logic              bit_start,
    output logic              sof_armed
);
    bt_len_t len;
    bt_evt_t evt;
    logic    fall;

    can_bt_cfg #(
        .PROP_W (PROP_W),
        .PH1_W  (PH1_W),
        .IPT_W  (IPT_W),
        .SJW_W  (SJW_W),
        .IPT_MAX(2)
    ) u_cfg (
        .cfg_prop(cfg_prop),
        .cfg_ph1 (cfg_ph1),
        .cfg_ipt (cfg_ipt),
        .cfg_sjw (cfg_sjw),
        .len     (len)
    );

    can_bt_edge u_edge (
        .clk (clk),
        .rst (rst),
        .tick(tq_tick),
        .rx  (rx_in),
        .fall(fall)
    );

    can_bt_timer u_timer (
        .clk       (clk),
        .rst       (rst),
        .tick      (tq_tick),
        .fall      (fall),
        .rx        (rx_in),
        .armed     (sof_armed),
        .len       (len),
        .evt       (evt),
        .sample_stb(sample_stb),
        .rx_bit    (rx_bit),
        .bit_start (bit_start)
    );

    can_bt_idle #(
        .IDLE_BITS(IDLE_BITS)
    ) u_idle (
        .clk       (clk),
        .rst       (rst),
        .sample_now(evt.sample),
        .rx        (rx_in),
        .hard_now  (evt.hard),
        .armed     (sof_armed)
    );
endmodule

// File: rtl/can_bt_chk.sv
`timescale 1ns/1ps
module can_bt_chk (
    input logic clk,
    input logic rst,
    input logic tq_tick,
    input logic sample_stb,
    input logic rx_bit,
    input logic bit_start,
    input logic sof_armed
);
    // R4: sample point and bit boundary are distinct quanta.
    assert_strobe_excl_R4: assert property (@(posedge clk) disable iff (rst)
        !(sample_stb && bit_start));

    // R1: every strobe stems from a quantum tick one cycle earlier.
    assert_strobe_after_tick_R1: assert property (@(posedge clk) disable iff (rst)
        (sample_stb || bit_start) |-> $past(tq_tick));

    // R4: the sampled level only moves at a sample strobe.
    assert_rxbit_hold_R4: assert property (@(posedge clk) disable iff (rst)
        !$stable(rx_bit) |-> sample_stb);

    // R7/R6: disarming coincides with the hard-synchronized bit start.
    assert_disarm_on_sync_R7: assert property (@(posedge clk) disable iff (rst)
        $fell(sof_armed) |-> bit_start);

    // R7: arming happens only at a recessive sample.
    assert_arm_on_recessive_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(sof_armed) |-> (sample_stb && rx_bit));
endmodule

bind can_bit_sync can_bt_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .tq_tick   (tq_tick),
    .sample_stb(sample_stb),
    .rx_bit    (rx_bit),
    .bit_start (bit_start),
    .sof_armed (sof_armed)
);

// File: tb/tb_can_bit_sync.sv
`timescale 1ns/1ps
module tb_can_bit_sync;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tq_tick = 1'b0;
    logic       rx_in = 1'b1;
    logic [2:0] cfg_prop = '0;
    logic [2:0] cfg_ph1 = '0;
    logic [1:0] cfg_ipt = '0;
    logic [1:0] cfg_sjw = '0;
    logic       sample_stb, rx_bit, bit_start, sof_armed;

    always #2.5 clk = ~clk;

    can_bit_sync dut (
        .clk(clk), .rst(rst), .tq_tick(tq_tick), .rx_in(rx_in),
        .cfg_prop(cfg_prop), .cfg_ph1(cfg_ph1), .cfg_ipt(cfg_ipt), .cfg_sjw(cfg_sjw),
        .sample_stb(sample_stb), .rx_bit(rx_bit), .bit_start(bit_start),
        .sof_armed(sof_armed)
    );

    typedef struct {
        int    kind;   // 0 = bit start, 1 = sample
        int    tq;
        logic  val;
        string req;
    } exp_t;

    exp_t  sb[$];
    int    errors = 0;
    int    checks = 0;
    int    tq_idx = -1;
    bit    finished = 1'b0;

    task automatic exp_bit(input int t, input string req);
        sb.push_back('{kind: 0, tq: t, val: 1'b0, req: req});
    endtask

    task automatic exp_smp(input int t, input logic v, input string req);
        sb.push_back('{kind: 1, tq: t, val: v, req: req});
    endtask

    task automatic check_eq(input string req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0b expected=%0b", req, what, act, exp);
        end
    endtask

    // Driver: one quantum per two clocks, inputs changed at falling edges.
    task automatic quanta(input int n, input logic lvl);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            tq_tick = 1'b1;
            rx_in   = lvl;
            tq_idx++;
            @(negedge clk);
            tq_tick = 1'b0;
        end
    endtask

    task automatic observe(input int kind, input logic v);
        exp_t e;
        checks++;
        if (sb.size() == 0) begin
            errors++;
            $display("FAIL R1 unexpected %s at quantum %0d: actual=event expected=none",
                     kind ? "sample" : "bit start", tq_idx);
        end else begin
            e = sb.pop_front();
            if (e.kind != kind || e.tq != tq_idx || (kind == 1 && e.val !== v)) begin
                errors++;
                $display("FAIL %s: actual=%s@%0d val=%0b expected=%s@%0d val=%0b",
                         e.req, kind ? "S" : "B", tq_idx, v,
                         e.kind ? "S" : "B", e.tq, e.val);
            end
        end
    endtask

    // Monitor: looks at strobes 1 ns after each rising edge.
    always begin
        @(posedge clk);
        #1;
        if (!rst) begin
            if (bit_start)  observe(0, 1'b0);
            if (sample_stb) observe(1, rx_bit);
        end
    end

    task automatic start_run(input logic [2:0] p, input logic [2:0] h1,
                             input logic [1:0] ipt, input logic [1:0] sj);
        @(negedge clk);
        rst = 1'b1;
        tq_tick = 1'b0;
        rx_in = 1'b1;
        cfg_prop = p; cfg_ph1 = h1; cfg_ipt = ipt; cfg_sjw = sj;
        tq_idx = -1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check_eq("R12", "sample_stb after reset", sample_stb, 1'b0);
        check_eq("R12", "bit_start after reset", bit_start, 1'b0);
        check_eq("R12", "rx_bit after reset", rx_bit, 1'b1);
        check_eq("R12", "sof_armed after reset", sof_armed, 1'b1);
    endtask

    task automatic drain();
        repeat (4) @(negedge clk);
        while (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            checks++;
            errors++;
            $display("FAIL %s: actual=missing expected=%s@%0d",
                     e.req, e.kind ? "S" : "B", e.tq);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL R1 watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        // Run A: Tprop=2, Tph1=3, ipt=2 -> Tph2=3, sjw=2; bit = 9 quanta.
        start_run(3'd1, 3'd2, 2'd2, 2'd1);
        exp_bit(0, "R12");  exp_smp(5, 1'b1, "R4");
        exp_bit(9, "R1");   exp_smp(14, 1'b1, "R4");
        exp_bit(18, "R1");
        exp_bit(20, "R6");  exp_smp(25, 1'b0, "R6");   // hard sync, no limit
        exp_bit(29, "R6");  exp_smp(36, 1'b0, "R8");   // ext clamped to 2, R11 second edge ignored
        exp_bit(40, "R11"); exp_smp(45, 1'b1, "R5");   // rising change without effect
        exp_bit(47, "R9");  exp_smp(52, 1'b0, "R9");
        exp_bit(54, "R10"); exp_smp(59, 1'b0, "R11");  // edge in this bit ignored
        exp_bit(63, "R11"); exp_smp(68, 1'b0, "R11");  // edge in sync segment ignored
        exp_bit(72, "R11"); exp_smp(78, 1'b0, "R8");   // ext of 1
        exp_bit(82, "R8");
        for (int k = 0; k < 11; k++) begin
            exp_smp(87 + 9 * k, 1'b1, "R7");
            exp_bit(91 + 9 * k, "R1");
        end
        exp_bit(185, "R7"); exp_smp(190, 1'b0, "R6");
        exp_bit(194, "R6"); exp_smp(199, 1'b0, "R1");
        exp_bit(203, "R1");

        quanta(20, 1'b1);
        quanta(1, 1'b0);
        check_eq("R7", "sof_armed after hard sync", sof_armed, 1'b0);
        quanta(8, 1'b0);
        quanta(3, 1'b1);
        quanta(1, 1'b0);
        quanta(1, 1'b1);
        quanta(11, 1'b0);
        quanta(1, 1'b1);
        quanta(7, 1'b0);
        quanta(1, 1'b1);
        quanta(1, 1'b0);
        quanta(1, 1'b1);
        quanta(6, 1'b0);
        quanta(1, 1'b1);
        quanta(9, 1'b0);
        quanta(1, 1'b1);
        quanta(9, 1'b0);
        quanta(95, 1'b1);
        check_eq("R7", "sof_armed after 10 recessive samples", sof_armed, 1'b0);
        quanta(1, 1'b1);
        check_eq("R7", "sof_armed after 11 recessive samples", sof_armed, 1'b1);
        quanta(7, 1'b1);
        quanta(1, 1'b0);
        check_eq("R7", "sof_armed after second hard sync", sof_armed, 1'b0);
        quanta(19, 1'b0);
        drain();

        // Run B: Tprop=1, Tph1=1, ipt=2 -> Tph2=2; bit = 5 quanta.
        start_run(3'd0, 3'd0, 2'd2, 2'd3);
        exp_bit(0, "R3");  exp_smp(2, 1'b1, "R2");
        exp_bit(5, "R3");  exp_smp(7, 1'b1, "R3");
        exp_bit(10, "R3"); exp_smp(12, 1'b1, "R3");
        exp_bit(15, "R3");
        quanta(16, 1'b1);
        drain();

        // Run C: Tprop=8, Tph1=8, ipt=3 capped -> Tph2=8; bit = 25 quanta.
        start_run(3'd7, 3'd7, 2'd3, 2'd0);
        exp_bit(0, "R2");  exp_smp(16, 1'b1, "R2");
        exp_bit(25, "R2"); exp_smp(41, 1'b1, "R2");
        exp_bit(50, "R3");
        quanta(51, 1'b1);
        drain();

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule